// File: doc/BRIEF.md
# Duty-Limited Three-Colour LED PWM Driver

This block drives a row of three-colour LEDs with pulse-width modulation. Each LED has a red, a green and a blue drive line. Each line has its own 8-bit intensity code. The block contains a clock-enable prescaler and a free-running period counter. Every channel compares the period counter against its own on-time. A channel's on-time is half of its requested code, rounded down. As a result no line is ever high for half of a period or more, and the full code range covers 0% to just under 50% brightness. Channels run side by side, so any mix of colours can be shown. Red and blue with green dark, for example, gives purple.

Software-facing logic outside this block writes an intensity code into a per-channel shadow register using a write strobe and a channel index. The shadow value moves into the channel's compare register only at a period boundary. That boundary is either the counter wrapping to zero or the first cycle after the block is switched on. Partial or stretched pulses therefore never occur.

A small sequencer with three named states controls the timing:
- `ST_OFF`: all lines are low, the prescaler and period counter are held at zero, and nothing is loaded.
- `ST_ARM`: this state lasts one cycle. All lines stay low and every shadow value is copied into its compare register.
- `ST_RUN`: the prescaler and counter advance and the lines toggle.

The state transitions are:
- `ST_OFF` to `ST_ARM` when enable is high.
- `ST_ARM` to `ST_RUN` when enable is still high.
- `ST_ARM` to `ST_OFF` when enable has dropped.
- `ST_RUN` to `ST_OFF` as soon as enable drops.
- Reset forces `ST_OFF` from any state.

Top module: `rgb_pwm_driver`

## Requirements
- R1: A synchronous reset drives every line low, clears the period counter and prescaler, and sets every shadow and compare register to code 0. After reset is released with enable high, every channel stays dark.
- R2: Channel index i = 3*led + colour drives `drive[i]`, where colour 0 is red, 1 is green and 2 is blue. A write to index i changes only that channel.
- R3: One period lasts 256 ticks, and one tick lasts PRESC clock cycles (default 2). A channel holding code D is high while the period counter is below floor(D/2). That gives exactly floor(D/2)*PRESC high cycles in every period.
- R4: For every code from 0 to 255, a channel is high for strictly less than half of a period (at most 127 ticks out of 256).
- R5: Codes 0 and 1 hold the line low for the whole period.
- R6: A code written during a period has no effect on that period. It takes effect from the next period boundary onward.
- R7: When enable is low, all lines go low on the next clock, and the counter and prescaler are cleared. On re-enable, the first cycle is dark (`ST_ARM`). The next cycle starts a period at count 0, so a channel with a non-zero on-time is high in that cycle.
- R8: A write with a channel index of NUM_LEDS*3 or above changes no channel.
- R9: Several channels may be high in the same cycle. With red and blue of one LED non-zero and green at code 0, red and blue are high together at the start of a period while green stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the PWM when high; hold all lines low when low |
| wr_en | input | 1 | Write strobe for a shadow intensity register |
| wr_chan | input | CH_W (3) | Channel index, 3*led + colour |
| wr_duty | input | DUTY_W (8) | Intensity code to store |
| drive | output | NUM_LEDS*3 (6) | Active-high channel drive lines |

## Verification
The bench sweeps every code from 0 to 255 and counts high cycles over whole periods. This catches a design that forgets to halve the code, which would run lines close to full duty. It also catches rounding up instead of down, or letting codes 0 and 1 produce a one-tick pulse. A write placed a few cycles into a period must leave that period's count unchanged; a design that loads the compare register straight away would show the new count at once. Disabling the block in the dark part of a period and then re-enabling it exposes a counter that is not cleared, because the channel would stay dark in the first running cycle. Writes to the two unused index values expose a decoder that aliases onto a real channel.

// File: rtl/rgb_pwm_pkg.sv
package rgb_pwm_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } seq_state_t;

    localparam int COL_RED   = 0;
    localparam int COL_GREEN = 1;
    localparam int COL_BLUE  = 2;
    localparam int COLOURS   = 3;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int PRESC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = run && (div_q == LAST);

    // R3: ticks never appear while the sequencer is stopped
    assert_tick_only_running_R3: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);

    // R7: a stop restarts the divider phase from zero
    assert_divider_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (div_q == '0));

endmodule

// File: rtl/pwm_period_seq.sv
module pwm_period_seq
    import rgb_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    output logic             run,
    output logic             load,
    output logic [CNT_W-1:0] per_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    seq_state_t       st_q, st_d;
    logic [CNT_W-1:0] per_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (enable) st_d = ST_ARM;
            ST_ARM:  st_d = enable ? ST_RUN : ST_OFF;
            ST_RUN:  if (!enable) st_d = ST_OFF;
            default: st_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // period counter
    always_ff @(posedge clk) begin
        if (rst || st_q != ST_RUN) begin
            per_q <= '0;
        end else if (tick) begin
            per_q <= per_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        run  = 1'b0;
        load = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                run  = 1'b0;
                load = 1'b0;
            end
            ST_ARM: begin
                run  = 1'b0;
                load = 1'b1;
            end
            ST_RUN: begin
                run  = 1'b1;
                load = tick && (per_q == CNT_MAX);
            end
            default: begin
                run  = 1'b0;
                load = 1'b0;
            end
        endcase
    end

    assign per_cnt = per_q;

    // R3: the counter holds between ticks while running
    assert_count_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && enable && !tick) |=> $stable(per_q));

    // R7: enable low stops the sequencer at the next edge
    assert_stop_on_disable_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (st_q == ST_OFF));

    // R7: one cycle after stopping the counter is back at zero
    assert_counter_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OFF) |=> (per_q == '0));

    // R7: running is always preceded by the arm cycle or by running
    assert_arm_before_run_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> ($past(st_q) == ST_ARM));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DUTY_W-1:0] wr_duty,
    input  logic              load,
    input  logic              run,
    input  logic [DUTY_W-1:0] per_cnt,
    output logic              drive
);
    localparam logic [DUTY_W-1:0] HALF = DUTY_W'(1) << (DUTY_W - 1);

    logic [DUTY_W-1:0] shadow_q;
    logic [DUTY_W-1:0] active_q;
    logic [DUTY_W-1:0] on_ticks;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (wr_hit) begin
            shadow_q <= wr_duty;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
        end else if (load) begin
            active_q <= shadow_q;
        end
    end

    // halving keeps the on-time below half the period
    assign on_ticks = active_q >> 1;
    assign drive    = run && (per_cnt < on_ticks);

    // R4: the line is never high in the upper half of the period
    assert_half_limit_R4: assert property (@(posedge clk) disable iff (rst)
        drive |-> (per_cnt < HALF));

    // R5: codes 0 and 1 keep the line dark
    assert_zero_dark_R5: assert property (@(posedge clk) disable iff (rst)
        (active_q < DUTY_W'(2)) |-> !drive);

    // R6: the compare value moves only at a boundary
    assert_load_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active_q));

    // R3: at the start of a period any non-zero on-time is lit
    assert_lit_at_start_R3: assert property (@(posedge clk) disable iff (rst)
        (run && per_cnt == '0 && on_ticks != '0) |-> drive);

endmodule

// File: rtl/rgb_pwm_driver.sv
module rgb_pwm_driver
    import rgb_pwm_pkg::*;
#(
    parameter int NUM_LEDS = 2,
    parameter int DUTY_W   = 8,
    parameter int PRESC    = 2,
    localparam int NUM_CH  = NUM_LEDS * COLOURS,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [DUTY_W-1:0] wr_duty,
    output logic [NUM_CH-1:0] drive
);
    logic              run;
    logic              tick;
    logic              load;
    logic [DUTY_W-1:0] per_cnt;

    pwm_tick_gen #(
        .PRESC (PRESC)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    pwm_period_seq #(
        .CNT_W (DUTY_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .tick    (tick),
        .run     (run),
        .load    (load),
        .per_cnt (per_cnt)
    );

    // R2: channel i belongs to led i/3, colour i%3
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic hit;
        assign hit = wr_en && (wr_chan == CH_W'(i));

        pwm_channel #(
            .DUTY_W (DUTY_W)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (hit),
            .wr_duty (wr_duty),
            .load    (load),
            .run     (run),
            .per_cnt (per_cnt),
            .drive   (drive[i])
        );
    end

    // R7: no line lights while the sequencer is not running
    assert_idle_dark_R7: assert property (@(posedge clk) disable iff (rst)
        !run |-> (drive == '0));

    // R1: the cycle after reset all lines are low
    assert_reset_dark_R1: assert property (@(posedge clk)
        rst |=> (drive == '0));

endmodule

// File: tb/test_rgb_pwm_driver.sv
module test_rgb_pwm_driver;
    localparam int NUM_LEDS = 2;
    localparam int DUTY_W   = 8;
    localparam int PRESC    = 2;
    localparam int NCH      = NUM_LEDS * 3;
    localparam int CH_W     = 3;
    localparam int P        = 256 * PRESC;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enable = 1'b0;
    logic              wr_en = 1'b0;
    logic [CH_W-1:0]   wr_chan = '0;
    logic [DUTY_W-1:0] wr_duty = '0;
    logic [NCH-1:0]    drive;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int c0 = 0;
    int cnt [NCH];
    int exp_d [NCH];
    bit done = 1'b0;

    rgb_pwm_driver #(
        .NUM_LEDS (NUM_LEDS),
        .DUTY_W   (DUTY_W),
        .PRESC    (PRESC)
    ) i_rgb_pwm_driver (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .wr_en   (wr_en),
        .wr_chan (wr_chan),
        .wr_duty (wr_duty),
        .drive   (drive)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int d);
        wr_en   = 1'b1;
        wr_chan = CH_W'(ch);
        wr_duty = DUTY_W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic align();
        while (((cyc - c0) % P) != 0) @(negedge clk);
    endtask

    // counts high cycles over one period; optional write at cycle wr_at
    task automatic measure(input int wr_at, input int wch, input int wval);
        for (int k = 0; k < NCH; k++) cnt[k] = 0;
        for (int i = 0; i < P; i++) begin
            if (i == wr_at) begin
                wr_en   = 1'b1;
                wr_chan = CH_W'(wch);
                wr_duty = DUTY_W'(wval);
            end
            for (int k = 0; k < NCH; k++) cnt[k] += int'(drive[k]);
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic check_counts(input string req);
        for (int k = 0; k < NCH; k++)
            chk(cnt[k] == (exp_d[k] / 2) * PRESC, req, $sformatf("ch%0d high cycles", k),
                cnt[k], (exp_d[k] / 2) * PRESC);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(drive == '0, "R1", "drive during reset", int'(drive), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(drive == '0, "R1", "drive after reset, disabled", int'(drive), 0);
    endtask

    task automatic t_enable();
        wr(0, 200);
        for (int k = 0; k < NCH; k++) exp_d[k] = 0;
        exp_d[0] = 200;
        enable = 1'b1;
        @(negedge clk);
        chk(drive == '0, "R7", "arm cycle dark", int'(drive), 0);
        @(negedge clk);
        chk(drive[0] == 1'b1, "R7", "first run cycle lit", int'(drive[0]), 1);
        c0 = cyc;
        measure(-1, 0, 0);
        check_counts("R3");
    endtask

    task automatic t_colours();
        align();
        wr(0, 255); wr(1, 0);   wr(2, 255);
        wr(3, 60);  wr(4, 120); wr(5, 180);
        exp_d = '{255, 0, 255, 60, 120, 180};
        align();
        chk(drive[2:0] == 3'b101, "R9", "purple mix at period start", int'(drive[2:0]), 5);
        measure(-1, 0, 0);
        check_counts("R2");
    endtask

    task automatic t_bad_index();
        align();
        wr(6, 7);
        wr(7, 7);
        align();
        measure(-1, 0, 0);
        check_counts("R8");
    endtask

    task automatic t_mid_write();
        align();
        wr(1, 40);
        exp_d[1] = 40;
        align();
        measure(5, 1, 200);
        chk(cnt[1] == 20 * PRESC, "R6", "period with mid-period write", cnt[1], 20 * PRESC);
        exp_d[1] = 200;
        measure(-1, 0, 0);
        chk(cnt[1] == 100 * PRESC, "R6", "following period", cnt[1], 100 * PRESC);
    endtask

    task automatic t_disable();
        int lit;
        align();
        repeat (150 * PRESC) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(drive == '0, "R7", "dark one cycle after disable", int'(drive), 0);
        lit = 0;
        for (int i = 0; i < 2 * P; i++) begin
            lit += $countones(drive);
            @(negedge clk);
        end
        chk(lit == 0, "R7", "high cycles while disabled", lit, 0);
        enable = 1'b1;
        @(negedge clk);
        chk(drive == '0, "R7", "arm cycle dark after re-enable", int'(drive), 0);
        @(negedge clk);
        chk(drive[0] == 1'b1, "R7", "counter restarts at zero", int'(drive[0]), 1);
        c0 = cyc;
        measure(-1, 0, 0);
        check_counts("R7");
    endtask

    task automatic t_sweep();
        for (int base = 0; base < 256; base += NCH) begin
            align();
            for (int k = 0; k < NCH; k++) begin
                exp_d[k] = (base + k > 255) ? 255 : base + k;
                wr(k, exp_d[k]);
            end
            align();
            measure(-1, 0, 0);
            for (int k = 0; k < NCH; k++) begin
                chk(cnt[k] == (exp_d[k] / 2) * PRESC, "R3",
                    $sformatf("code %0d high cycles", exp_d[k]), cnt[k], (exp_d[k] / 2) * PRESC);
                chk(cnt[k] * 2 < P, "R4", $sformatf("code %0d below half", exp_d[k]),
                    cnt[k], P / 2 - 1);
                if (exp_d[k] < 2)
                    chk(cnt[k] == 0, "R5", $sformatf("code %0d dark", exp_d[k]), cnt[k], 0);
            end
        end
    endtask

    task automatic t_reset_mid();
        align();
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(drive == '0, "R1", "dark after mid-run reset", int'(drive), 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        c0 = cyc;
        for (int k = 0; k < NCH; k++) exp_d[k] = 0;
        measure(-1, 0, 0);
        check_counts("R1");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_enable();
        t_colours();
        t_bad_index();
        t_mid_write();
        t_disable();
        t_sweep();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule